// File: doc/BRIEF.md
# Multi-Channel Down-Counting Interval Timer

This block holds several identical timer channels that share one source clock and one free-running prescale divider. Each channel holds a 64-bit interval and a 64-bit live count. Once enabled, it decrements the count on the ticks of its chosen prescale rate. When the count runs out, the channel raises a pending flag. In periodic mode it then restarts from the interval. In one-shot mode it parks at zero and turns itself off.

Software reaches the block through a single-cycle register port. A write takes effect on the clock edge where `wr_en` is high. Read data is combinational from `addr`. The pending flags clear when a one is written to them. A per-channel enable mask gates the flags onto one interrupt line. Turning a channel off is not immediate: the channel keeps counting for a fixed number of source-clock cycles after the write that clears its enable bit.

Top module: `mct_top`

## Requirements
- R1: After reset every register reads zero, the prescale divider is zero and `irq` is low.
- R2: The register map uses byte offsets. The mask is at 0x00 and the pending flags are at 0x04, bit c for channel c. Channel c uses base 0x20*c with these offsets: control at +0x10, interval low/high at +0x14/+0x18, count low/high at +0x1C/+0x20. Writes to any other offset, including channels at or above NCH, change nothing, and reads of those offsets return zero.
- R3: Control bit 0 is enable, bit 1 is load-request, bits 6:4 are the prescale code and bit 7 selects one-shot (1) or periodic (0). All other control bits read zero.
- R4: A 7-bit divider starts at zero and increments every clock. Prescale code n gives a tick in every cycle where the divider's low n bits are all ones, so the tick rate is once per 2^n clocks. Code 0 ticks every clock.
- R5: A channel counts only while it is running. On a tick with load-request set, the channel copies the full 64-bit interval into the count and clears load-request. That tick does not decrement the count.
- R6: On any other tick, a count above 1 decrements by one. A count of 0 or 1 expires instead. In periodic mode an expiry reloads the interval.
- R7: In one-shot mode an expiry sets the count to zero and clears the enable bit. The count then holds.
- R8: An expiry sets that channel's pending flag. Writing 1 to a flag bit clears it. If an expiry and a clear happen in the same cycle, the expiry wins.
- R9: `irq` is high exactly when some channel has both its pending flag and its mask bit set.
- R10: A write that clears the enable bit of an enabled channel lets the channel keep running for STOP_LAT further clock cycles. After that its count stops changing.
- R11: While a channel is not running, its count never changes, and writes to its interval do not touch the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | ADDR_W | Byte offset of the register to read or write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench builds the block with NCH=3, STOP_LAT=2 and ADDR_W=8. Three channels let the bench run one periodic channel, one one-shot channel and one slow-prescale channel with different settings. Offset 0x70, which is the first offset past the last channel, then checks that out-of-range channel decode is ignored. A stop latency of two cycles keeps the run-on window short, so every cycle of it is compared. The 64-bit load is checked by reading the high count word after an interval whose high word is non-zero.

// File: rtl/mct_pkg.sv
package mct_pkg;

  localparam int PSC_CODES = 8;
  localparam int DIV_W     = PSC_CODES - 1;

  typedef enum logic [2:0] {
    RK_NONE, RK_MASK, RK_FLAG, RK_CTL, RK_IVL_LO, RK_IVL_HI, RK_CNT_LO, RK_CNT_HI
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [7:0] ch;
  } reg_sel_t;

  typedef struct packed {
    logic       one;
    logic [2:0] psc;
    logic       rld;
    logic       en;
  } ctl_t;

  function automatic ctl_t ctl_from_word(logic [31:0] w);
    ctl_t c;
    c.one = w[7];
    c.psc = w[6:4];
    c.rld = w[1];
    c.en  = w[0];
    return c;
  endfunction

  function automatic logic [31:0] ctl_to_word(ctl_t c);
    return {24'd0, c.one, c.psc, 2'b00, c.rld, c.en};
  endfunction

  // Count of 0 or 1 means this tick is the expiry tick.
  function automatic logic is_expiring(logic [63:0] cnt);
    return cnt <= 64'd1;
  endfunction

  function automatic reg_sel_t decode_addr(logic [31:0] a, int nch);
    reg_sel_t   s;
    logic [31:0] rel;
    s.kind = RK_NONE;
    s.ch   = '0;
    rel    = a - 32'h10;
    if (a == 32'h0)      s.kind = RK_MASK;
    else if (a == 32'h4) s.kind = RK_FLAG;
    else if (a >= 32'h10 && (rel >> 5) < unsigned'(nch)) begin
      s.ch = rel[12:5];
      case (rel[4:0])
        5'h00:   s.kind = RK_CTL;
        5'h04:   s.kind = RK_IVL_LO;
        5'h08:   s.kind = RK_IVL_HI;
        5'h0C:   s.kind = RK_CNT_LO;
        5'h10:   s.kind = RK_CNT_HI;
        default: s.kind = RK_NONE;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/mct_prescaler.sv
module mct_prescaler
  import mct_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  output logic [PSC_CODES-1:0] tick_o
);

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  assign tick_o[0] = 1'b1;

  for (genvar n = 1; n < PSC_CODES; n++) begin : g_tick
    assign tick_o[n] = &div_q[n-1:0];

    // R4: a divided tick never lasts two cycles in a row
    p_tick_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o[n] |=> !tick_o[n]);
  end

endmodule

// File: rtl/mct_channel.sv
module mct_channel
  import mct_pkg::*;
#(
  parameter int STOP_LAT = 2,
  localparam int LW = $clog2(STOP_LAT + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_we,
  input  logic                 lo_we,
  input  logic                 hi_we,
  input  logic [31:0]          wdata,
  input  logic [PSC_CODES-1:0] tick_vec,
  output logic [31:0]          ctl_o,
  output logic [63:0]          ivl_o,
  output logic [63:0]          cnt_o,
  output logic                 expire_o
);

  ctl_t          ctl_q, ctl_d;
  logic [63:0]   ivl_q, cnt_q, cnt_d;
  logic [LW-1:0] linger_q, linger_d;
  logic          run, tick;

  assign run  = ctl_q.en || (linger_q != '0);
  assign tick = tick_vec[ctl_q.psc];

  always_comb begin
    ctl_d    = ctl_q;
    cnt_d    = cnt_q;
    expire_o = 1'b0;
    linger_d = (linger_q != '0) ? linger_q - LW'(1) : '0;
    if (run && tick) begin
      if (ctl_q.rld) begin
        cnt_d     = ivl_q;
        ctl_d.rld = 1'b0;
      end else if (is_expiring(cnt_q)) begin
        expire_o = 1'b1;
        if (ctl_q.one) begin
          cnt_d    = '0;
          ctl_d.en = 1'b0;
          linger_d = '0;
        end else begin
          cnt_d = ivl_q;
        end
      end else begin
        cnt_d = cnt_q - 64'd1;
      end
    end
    if (ctl_we) begin
      ctl_d = ctl_from_word(wdata);
      if (ctl_q.en && !wdata[0]) linger_d = LW'(STOP_LAT);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      ivl_q    <= '0;
      cnt_q    <= '0;
      linger_q <= '0;
    end else begin
      ctl_q    <= ctl_d;
      cnt_q    <= cnt_d;
      linger_q <= linger_d;
      if (lo_we) ivl_q[31:0]  <= wdata;
      if (hi_we) ivl_q[63:32] <= wdata;
    end
  end

  assign ctl_o = ctl_to_word(ctl_q);
  assign ivl_o = ivl_q;
  assign cnt_o = cnt_q;

  // R5: a load tick copies the interval and drops the request
  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run && tick && ctl_q.rld && !ctl_we |=> !ctl_q.rld && cnt_q == $past(ivl_q));
  // R6: periodic expiry restarts from the interval
  p_periodic_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o && !ctl_q.one |=> cnt_q == $past(ivl_q));
  // R7: one-shot expiry parks at zero, disabled
  p_oneshot_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o && ctl_q.one && !ctl_we |=> !ctl_q.en && cnt_q == 64'd0);
  // R10: clearing enable does not stop the channel on the next cycle
  p_stop_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && ctl_q.en && !wdata[0] |=> run);
  // R11: an idle or untick cycle leaves the count alone
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && tick) |=> $stable(cnt_q));

endmodule

// File: rtl/mct_top.sv
module mct_top
  import mct_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int STOP_LAT = 2,
  parameter int ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);

  reg_sel_t             sel;
  logic [PSC_CODES-1:0] tick_vec;
  logic [NCH-1:0]       mask_q, flag_q, expire;
  logic [NCH-1:0]       clr_bits;
  logic [31:0]          ctl_w [NCH];
  logic [63:0]          ivl_w [NCH];
  logic [63:0]          cnt_w [NCH];

  assign sel = decode_addr(32'(addr), NCH);

  mct_prescaler i_psc (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick_vec)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = wr_en && (sel.ch == 8'(c));
    mct_channel #(.STOP_LAT(STOP_LAT)) i_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_we   (hit && sel.kind == RK_CTL),
      .lo_we    (hit && sel.kind == RK_IVL_LO),
      .hi_we    (hit && sel.kind == RK_IVL_HI),
      .wdata    (wdata),
      .tick_vec (tick_vec),
      .ctl_o    (ctl_w[c]),
      .ivl_o    (ivl_w[c]),
      .cnt_o    (cnt_w[c]),
      .expire_o (expire[c])
    );

    // R8: an expiry always leaves the flag set
    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      expire[c] |=> flag_q[c]);
  end

  assign clr_bits = (wr_en && sel.kind == RK_FLAG) ? wdata[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      flag_q <= '0;
    end else begin
      flag_q <= (flag_q & ~clr_bits) | expire;
      if (wr_en && sel.kind == RK_MASK) mask_q <= wdata[NCH-1:0];
    end
  end

  assign irq = |(flag_q & mask_q);

  always_comb begin
    rdata = '0;
    case (sel.kind)
      RK_MASK: rdata = 32'(mask_q);
      RK_FLAG: rdata = 32'(flag_q);
      default: begin
        for (int c = 0; c < NCH; c++) begin
          if (sel.ch == 8'(c)) begin
            case (sel.kind)
              RK_CTL:    rdata = ctl_w[c];
              RK_IVL_LO: rdata = ivl_w[c][31:0];
              RK_IVL_HI: rdata = ivl_w[c][63:32];
              RK_CNT_LO: rdata = cnt_w[c][31:0];
              RK_CNT_HI: rdata = cnt_w[c][63:32];
              default:   rdata = '0;
            endcase
          end
        end
      end
    endcase
  end

  // R9: the line only rises with some mask bit set
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0));
  // R8: a clear without a coinciding expiry removes the bit
  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && sel.kind == RK_FLAG && expire == '0 |=>
      (flag_q & $past(wdata[NCH-1:0])) == '0);

endmodule

// File: tb/test_mct_top.sv
module test_mct_top;

  localparam int NCH = 3;
  localparam int SL  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int    vectors = 0;
  int    fails = 0;
  bit    done = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  mct_top #(.NCH(NCH), .STOP_LAT(SL), .ADDR_W(8)) i_mct_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // Behavioural reference model
  int           m_div;
  bit           m_en [NCH], m_rld [NCH], m_one [NCH];
  int           m_psc [NCH], m_lin [NCH];
  logic [63:0]  m_ivl [NCH], m_cnt [NCH];
  logic [NCH-1:0] m_mask, m_flag;

  function automatic bit m_tick(int n);
    return (m_div % (1 << n)) == (1 << n) - 1;
  endfunction

  function automatic logic [31:0] m_read(int a);
    int c, s;
    if (a == 0) return 32'(m_mask);
    if (a == 4) return 32'(m_flag);
    if (a < 16) return 0;
    c = (a - 16) / 32;
    s = (a - 16) % 32;
    if (c >= NCH) return 0;
    if (s == 0)  return 32'((int'(m_one[c]) << 7) | (m_psc[c] << 4) | (int'(m_rld[c]) << 1) | int'(m_en[c]));
    if (s == 4)  return m_ivl[c][31:0];
    if (s == 8)  return m_ivl[c][63:32];
    if (s == 12) return m_cnt[c][31:0];
    if (s == 16) return m_cnt[c][63:32];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_mask = '0; m_flag = '0;
      for (int c = 0; c < NCH; c++) begin
        m_en[c] = 0; m_rld[c] = 0; m_one[c] = 0; m_psc[c] = 0; m_lin[c] = 0;
        m_ivl[c] = '0; m_cnt[c] = '0;
      end
    end else begin
      logic [NCH-1:0] exp_v;
      int a;
      exp_v = '0;
      a = int'(addr);
      for (int c = 0; c < NCH; c++) begin
        bit running, was_en;
        running = m_en[c] || m_lin[c] > 0;
        was_en  = m_en[c];
        if (m_lin[c] > 0) m_lin[c]--;
        if (running && m_tick(m_psc[c])) begin
          if (m_rld[c]) begin
            m_cnt[c] = m_ivl[c]; m_rld[c] = 0;
          end else if (m_cnt[c] == 0 || m_cnt[c] == 1) begin
            exp_v[c] = 1'b1;
            if (m_one[c]) begin m_cnt[c] = 0; m_en[c] = 0; m_lin[c] = 0; end
            else m_cnt[c] = m_ivl[c];
          end else m_cnt[c] = m_cnt[c] - 1;
        end
        if (wr_en && a == 16 + 32*c) begin
          m_en[c] = wdata[0]; m_rld[c] = wdata[1];
          m_psc[c] = int'(wdata[6:4]); m_one[c] = wdata[7];
          if (was_en && !wdata[0]) m_lin[c] = SL;
        end
        if (wr_en && a == 20 + 32*c) m_ivl[c][31:0] = wdata;
        if (wr_en && a == 24 + 32*c) m_ivl[c][63:32] = wdata;
      end
      if (wr_en && a == 4) m_flag = m_flag & ~wdata[NCH-1:0];
      m_flag = m_flag | exp_v;
      if (wr_en && a == 0) m_mask = wdata[NCH-1:0];
      m_div++;
    end
  end

  task automatic check();
    logic [31:0] e;
    logic ei;
    @(negedge clk);
    e  = m_read(int'(addr));
    ei = |(m_flag & m_mask);
    vectors++;
    if (rdata !== e) begin
      fails++;
      $display("FAIL %s rdata at 0x%02h: actual 0x%08h expected 0x%08h", cur_req, addr, rdata, e);
    end
    vectors++;
    if (irq !== ei) begin
      fails++;
      $display("FAIL %s irq: actual %0b expected %0b", cur_req, irq, ei);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    check();
    wr_en = 1'b0;
  endtask

  task automatic watch(input logic [7:0] a, input int n);
    addr = a;
    for (int i = 0; i < n; i++) check();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    for (int a = 0; a < 8'h74; a += 4) begin addr = 8'(a); check(); end

    cur_req = "R3";
    wr(8'h10, 32'hFFFF_FF70);
    watch(8'h10, 2);
    wr(8'h10, 32'h0);

    cur_req = "R2";
    wr(8'h70, 32'h0000_00FF);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'hFC, 32'h1234_5678);
    watch(8'h70, 2); watch(8'h0C, 1); watch(8'hFC, 1); watch(8'h08, 1);

    cur_req = "R5";
    wr(8'h14, 32'd5);
    wr(8'h00, 32'h1);
    wr(8'h10, 32'h03);
    cur_req = "R6";
    watch(8'h1C, 20);
    cur_req = "R9";
    watch(8'h04, 2);
    cur_req = "R8";
    wr(8'h04, 32'h1);
    watch(8'h04, 4);

    cur_req = "R5";
    wr(8'h34, 32'd3);
    wr(8'h38, 32'd1);
    wr(8'h30, 32'h03);
    watch(8'h40, 3);
    cur_req = "R10";
    wr(8'h30, 32'h00);
    watch(8'h3C, 6);
    cur_req = "R11";
    wr(8'h34, 32'd7);
    watch(8'h3C, 4);

    cur_req = "R7";
    wr(8'h54, 32'd4);
    wr(8'h50, 32'h93);
    watch(8'h5C, 14);
    watch(8'h50, 2);
    cur_req = "R9";
    wr(8'h00, 32'h4);
    watch(8'h04, 2);
    wr(8'h00, 32'h0);
    watch(8'h04, 2);
    wr(8'h04, 32'h7);

    cur_req = "R4";
    wr(8'h54, 32'd3);
    wr(8'h50, 32'h33);
    watch(8'h5C, 40);
    cur_req = "R6";
    wr(8'h10, 32'h00);
    watch(8'h1C, 12);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule